// File: doc/BRIEF.md
# FP32 Special-Value Classifier

This block labels each 32-bit floating-point word on an input stream as one of five kinds: ordinary, zero, NaN, positive infinity or negative infinity. It does not decode the IEEE fields with fixed logic. Each of the four special kinds has a programmable pattern word and a programmable select word. A kind is recognised when the input, ANDed with its select word, equals its pattern word. The reset contents give ordinary IEEE detection. Software can reprogram the pairs to widen, narrow or redefine a kind, for example to catch signalling NaNs or to ignore the sign bit.

The eight pattern and select words sit behind a simple word-indexed register port with a write strobe and a combinational read-back. Stream words arrive with a valid strobe. One clock later the block presents a valid flag together with the result in two forms: a 3-bit class code and a 5-bit one-hot vector. A fixed priority decides when more than one kind matches.

Top module: `fpsv_classifier`

## Requirements
- R1: After reset the register words read back, by index, as: 0 zero pattern 0x00000000, 1 zero select 0x00000000, 2 NaN pattern 0x7fc00000, 3 NaN select 0x7fc00000, 4 +Inf pattern 0x7f800000, 5 +Inf select 0xffffffff, 6 -Inf pattern 0xff800000, 7 -Inf select 0xffffffff.
- R2: Every one of the eight words can be written through `cfg_we`/`cfg_addr`/`cfg_wdata`. Once written, `cfg_rdata` at that index returns the written value.
- R3: A kind matches an input word `x` when `(x & select) == pattern`, using that kind's current register pair.
- R4: When several kinds match, the reported class is chosen in the order NaN, then +Inf, then -Inf, then zero. A word that matches no kind is reported as ordinary.
- R5: The class codes are ordinary = 0, zero = 1, NaN = 2, +Inf = 3 and -Inf = 4. `out_onehot` has exactly one bit set, at the bit position equal to the class code.
- R6: `out_valid` is high in the cycle after each cycle with `in_valid` high. The class reported then belongs to the word presented with that `in_valid`, and results come out in input order.
- R7: In a cycle after one without `in_valid`, `out_valid` is low and `out_class`/`out_onehot` keep their previous values.
- R8: A register write applies to input words sampled on the clock edge after the write edge. A word presented in the same cycle as a write is classified with the old contents.
- R9: With the reset select word of 0 the zero kind matches every word. As a result, under reset contents any word that is not a quiet NaN or an exact infinity is reported as zero, including signalling NaNs. Once the zero select is set to 0x7fffffff, both +0 and -0 report zero and all other unmatched words report ordinary.
- R10: During and right after reset, `out_valid` is 0, `out_class` is 0 (ordinary) and `out_onehot` is 5'b00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index (0..7) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Contents of the word at `cfg_addr` |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 32 | FP32 word to classify |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_class | output | 3 | Encoded class |
| out_onehot | output | 5 | One-hot class, bit index equals class code |

## Verification
The bench targets overlap among kinds. It reprograms +Inf and -Inf to match everything and checks that NaN still wins, then that +Inf beats -Inf, then that -Inf beats zero; a design with the chain misordered would report the wrong lower-priority kind. It checks the surprising reset result, where a mask of zero makes an ordinary 1.0 or a signalling NaN report as zero; a design that hard-coded IEEE decoding would return ordinary. It issues a write in the same cycle as a stream word and again one cycle before one, so a design that bypassed write data into the compare, or delayed it by an extra stage, classifies one of the two words differently. Idle gaps check that the result holds and that valid drops.

// File: rtl/fpsv_pkg.sv
package fpsv_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_SLOTS = 4;
    localparam int NUM_CODES = 5;

    // Slot index order fixes the register layout: pattern at 2*slot, select at 2*slot+1
    localparam int SLOT_ZERO = 0;
    localparam int SLOT_NAN  = 1;
    localparam int SLOT_PINF = 2;
    localparam int SLOT_NINF = 3;

    typedef enum logic [2:0] {
        CLS_ORD  = 3'd0,
        CLS_ZERO = 3'd1,
        CLS_NAN  = 3'd2,
        CLS_PINF = 3'd3,
        CLS_NINF = 3'd4
    } cls_e;

    function automatic logic [WORD_W-1:0] slot_rst_pattern(input int slot);
        case (slot)
            SLOT_NAN:  return 32'h7fc0_0000;
            SLOT_PINF: return 32'h7f80_0000;
            SLOT_NINF: return 32'hff80_0000;
            default:   return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] slot_rst_select(input int slot);
        case (slot)
            SLOT_NAN:  return 32'h7fc0_0000;
            SLOT_PINF: return 32'hffff_ffff;
            SLOT_NINF: return 32'hffff_ffff;
            default:   return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/fpsv_regbank.sv
module fpsv_regbank
    import fpsv_pkg::*;
#(
    parameter  int DW    = WORD_W,
    parameter  int NSLOT = NUM_SLOTS,
    localparam int NWORD = 2 * NSLOT,
    localparam int AW    = $clog2(NWORD)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic [NSLOT-1:0][DW-1:0]   pattern,
    output logic [NSLOT-1:0][DW-1:0]   select
);

    typedef struct packed {
        logic [NWORD-1:0][DW-1:0] word;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic bank_t reset_bank();
        bank_t b;
        for (int s = 0; s < NSLOT; s++) begin
            b.word[2*s]   = DW'(slot_rst_pattern(s));
            b.word[2*s+1] = DW'(slot_rst_select(s));
        end
        return b;
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (int'(addr) < NWORD)) begin
            bank_d.word[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= reset_bank();
        else        bank_q <= bank_d;
    end

    assign rdata = (int'(addr) < NWORD) ? bank_q.word[addr] : '0;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign pattern[s] = bank_q.word[2*s];
        assign select[s]  = bank_q.word[2*s+1];
    end

    // R2: a written word is held in the bank from the next cycle on
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bank_q.word[$past(addr)] == $past(wdata)));

    // R2: with no write the bank does not change
    a_r2_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q));

endmodule

// File: rtl/fpsv_match.sv
module fpsv_match
    import fpsv_pkg::*;
#(
    parameter int DW    = WORD_W,
    parameter int NSLOT = NUM_SLOTS
) (
    input  logic [DW-1:0]              data,
    input  logic [NSLOT-1:0][DW-1:0]   pattern,
    input  logic [NSLOT-1:0][DW-1:0]   select,
    output logic [NSLOT-1:0]           hit
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
        assign hit[s] = ((data & select[s]) == pattern[s]);
    end

endmodule

// File: rtl/fpsv_prio.sv
module fpsv_prio
    import fpsv_pkg::*;
(
    input  logic [NUM_SLOTS-1:0] hit,
    output cls_e                 cls,
    output logic [NUM_CODES-1:0] onehot
);

    // Encoded result: priority chain NaN > +Inf > -Inf > zero > ordinary
    always_comb begin
        if      (hit[SLOT_NAN])  cls = CLS_NAN;
        else if (hit[SLOT_PINF]) cls = CLS_PINF;
        else if (hit[SLOT_NINF]) cls = CLS_NINF;
        else if (hit[SLOT_ZERO]) cls = CLS_ZERO;
        else                     cls = CLS_ORD;
    end

    // One-hot result built from masked hits, independent of the chain above
    always_comb begin
        onehot           = '0;
        onehot[CLS_NAN]  = hit[SLOT_NAN];
        onehot[CLS_PINF] = hit[SLOT_PINF] & ~hit[SLOT_NAN];
        onehot[CLS_NINF] = hit[SLOT_NINF] & ~hit[SLOT_NAN] & ~hit[SLOT_PINF];
        onehot[CLS_ZERO] = hit[SLOT_ZERO] & ~hit[SLOT_NAN] & ~hit[SLOT_PINF]
                         & ~hit[SLOT_NINF];
        onehot[CLS_ORD]  = ~(|hit);
    end

endmodule

// File: rtl/fpsv_classifier.sv
module fpsv_classifier
    import fpsv_pkg::*;
#(
    parameter  int DW = WORD_W,
    localparam int AW = $clog2(2 * NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [DW-1:0]        cfg_rdata,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_data,
    output logic                 out_valid,
    output logic [2:0]           out_class,
    output logic [NUM_CODES-1:0] out_onehot
);

    logic [NUM_SLOTS-1:0][DW-1:0] pattern;
    logic [NUM_SLOTS-1:0][DW-1:0] select;
    logic [NUM_SLOTS-1:0]         hit;
    cls_e                         cls;
    logic [NUM_CODES-1:0]         onehot;

    typedef struct packed {
        logic                 vld;
        cls_e                 cls;
        logic [NUM_CODES-1:0] oh;
    } res_t;

    localparam res_t RES_RESET = '{vld: 1'b0, cls: CLS_ORD,
                                   oh: NUM_CODES'(1) << CLS_ORD};

    res_t res_d, res_q;

    fpsv_regbank #(.DW(DW), .NSLOT(NUM_SLOTS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .pattern (pattern),
        .select  (select)
    );

    fpsv_match #(.DW(DW), .NSLOT(NUM_SLOTS)) u_match (
        .data    (in_data),
        .pattern (pattern),
        .select  (select),
        .hit     (hit)
    );

    fpsv_prio u_prio (
        .hit    (hit),
        .cls    (cls),
        .onehot (onehot)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.cls = cls;
            res_d.oh  = onehot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= RES_RESET;
        else        res_q <= res_d;
    end

    assign out_valid  = res_q.vld;
    assign out_class  = res_q.cls;
    assign out_onehot = res_q.oh;

    // R6: a valid input yields a valid result one cycle later
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7: no input, no result, and the last result holds
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_class) && $stable(out_onehot)));

    // R5: exactly one one-hot bit, at the position of the code
    a_r5_onehot_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_onehot) == 1));
    a_r5_code_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_onehot == (NUM_CODES'(1) << out_class)));

    // R4: NaN match always wins; no match gives ordinary
    a_r4_nan_first: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit[SLOT_NAN]) |=> (out_class == CLS_NAN));
    a_r4_none_ordinary: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(|hit)) |=> (out_class == CLS_ORD));

endmodule

// File: tb/fpsv_classifier_tb_top.sv
module fpsv_classifier_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        in_valid;
    logic [31:0] in_data;
    logic        out_valid;
    logic [2:0]  out_class;
    logic [4:0]  out_onehot;

    always #4 clk = ~clk; // 125 MHz

    fpsv_classifier dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_class  (out_class),
        .out_onehot (out_onehot)
    );

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    logic [31:0] model [8];
    int          exp_q [$];
    string       tag_q [$];
    logic [2:0]  last_cls = 3'd0;
    logic [4:0]  last_oh  = 5'b00001;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R1 reset contents, word index order pattern/select per kind
    task automatic model_reset();
        model[0] = 32'h0000_0000; model[1] = 32'h0000_0000;
        model[2] = 32'h7fc0_0000; model[3] = 32'h7fc0_0000;
        model[4] = 32'h7f80_0000; model[5] = 32'hffff_ffff;
        model[6] = 32'hff80_0000; model[7] = 32'hffff_ffff;
    endtask

    // R3/R4: match rule and priority, codes per R5
    function automatic int classify(input logic [31:0] d);
        bit z, n, p, m;
        z = ((d & model[1]) == model[0]);
        n = ((d & model[3]) == model[2]);
        p = ((d & model[5]) == model[4]);
        m = ((d & model[7]) == model[6]);
        if (n) return 2;
        if (p) return 3;
        if (m) return 4;
        if (z) return 1;
        return 0;
    endfunction

    task automatic clear_drive();
        cfg_we   = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic send(input logic [31:0] d, input string tag);
        @(negedge clk);
        clear_drive();
        in_valid = 1'b1;
        in_data  = d;
        exp_q.push_back(classify(d));
        tag_q.push_back(tag);
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] v);
        @(negedge clk);
        clear_drive();
        cfg_we    = 1'b1;
        cfg_addr  = 3'(idx);
        cfg_wdata = v;
        model[idx] = v;
    endtask

    task automatic send_with_write(input logic [31:0] d, input int idx,
                                   input logic [31:0] v, input string tag);
        @(negedge clk);
        clear_drive();
        in_valid  = 1'b1;
        in_data   = d;
        cfg_we    = 1'b1;
        cfg_addr  = 3'(idx);
        cfg_wdata = v;
        exp_q.push_back(classify(d));
        tag_q.push_back(tag);
        model[idx] = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clear_drive();
        end
    endtask

    task automatic rd_check(input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        clear_drive();
        cfg_addr = 3'(idx);
        #1;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 result without input", 32'(out_class), 32'hffff_ffff);
                end else begin
                    automatic int    e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(out_class == 3'(e), {t, " class"}, 32'(out_class), 32'(e));
                    chk(out_onehot == (5'b00001 << e), {"R5 onehot ", t},
                        32'(out_onehot), 32'(5'b00001 << e));
                    last_cls = 3'(e);
                    last_oh  = 5'b00001 << e;
                end
            end else begin
                chk(out_class == last_cls && out_onehot == last_oh, "R7 hold",
                    {24'd0, out_onehot, out_class}, {24'd0, last_oh, last_cls});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_valid = 1'b0; in_data = '0;
        model_reset();
        repeat (3) @(negedge clk);
        // R10 reset outputs
        chk(out_valid == 1'b0, "R10 valid in reset", 32'(out_valid), 0);
        chk(out_class == 3'd0, "R10 class in reset", 32'(out_class), 0);
        chk(out_onehot == 5'b00001, "R10 onehot in reset", 32'(out_onehot), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_onehot == 5'b00001, "R10 after release",
            {27'd0, out_onehot}, 1);
        mon_on = 1'b1;

        // R1 reset register contents
        for (int i = 0; i < 8; i++) rd_check(i, model[i], "R1 reset word");

        // R3/R9 default detection, back to back
        send(32'h7fc0_0000, "R3 quiet NaN");
        send(32'hffc0_0001, "R3 negative quiet NaN");
        send(32'h7f80_0000, "R3 +Inf");
        send(32'hff80_0000, "R3 -Inf");
        send(32'h0000_0000, "R3 +0");
        send(32'h3f80_0000, "R9 one reports zero");
        send(32'h7f80_0001, "R9 signalling NaN reports zero");
        idle(3);

        // R2 write and read back every word, then restore
        for (int i = 0; i < 8; i++) cfg_write(i, 32'hA500_0000 ^ (32'h0101_0101 * i));
        for (int i = 0; i < 8; i++) rd_check(i, 32'hA500_0000 ^ (32'h0101_0101 * i), "R2 readback");
        begin
            logic [31:0] dflt [8];
            dflt[0] = 32'h0; dflt[1] = 32'h0; dflt[2] = 32'h7fc0_0000; dflt[3] = 32'h7fc0_0000;
            dflt[4] = 32'h7f80_0000; dflt[5] = 32'hffff_ffff;
            dflt[6] = 32'hff80_0000; dflt[7] = 32'hffff_ffff;
            for (int i = 0; i < 8; i++) cfg_write(i, dflt[i]);
        end
        rd_check(3, 32'h7fc0_0000, "R2 restored");

        // R9 ordinary once zero select ignores sign
        cfg_write(1, 32'h7fff_ffff);
        send(32'h8000_0000, "R9 -0 is zero");
        send(32'h0000_0000, "R9 +0 is zero");
        send(32'h3f80_0000, "R9 one is ordinary");
        send(32'h0000_0001, "R9 denormal is ordinary");
        idle(2);

        // R4 priority: +Inf and -Inf made to match all
        cfg_write(5, 32'h0);
        cfg_write(4, 32'h0);
        send(32'h7fc0_0000, "R4 NaN beats +Inf");
        send(32'h1234_5678, "R4 +Inf beats zero");
        cfg_write(7, 32'h0);
        cfg_write(6, 32'h0);
        send(32'h0000_0000, "R4 +Inf beats -Inf and zero");
        cfg_write(4, 32'h7f80_0000);
        cfg_write(5, 32'hffff_ffff);
        send(32'h0000_0000, "R4 -Inf beats zero");
        send(32'h7f80_0000, "R4 +Inf beats -Inf");
        cfg_write(6, 32'hff80_0000);
        cfg_write(7, 32'hffff_ffff);
        idle(2);

        // R8 write timing
        send_with_write(32'h1234_5678, 6, 32'h1234_5678, "R8 same-cycle uses old");
        send(32'h1234_5678, "R8 next cycle uses new");
        idle(1);
        send_with_write(32'hff80_0000, 6, 32'hff80_0000, "R8 same-cycle old pattern");
        send(32'hff80_0000, "R8 restored -Inf");
        idle(3);

        // R6 all results returned
        chk(exp_q.size() == 0, "R6 all results returned", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule